// File: doc/BRIEF.md
# I2C Register Target

This block lets an I2C bus host read and write a small bank of 8-bit registers. Two strap pins pick one of four 7-bit bus addresses. SCL and SDA come in asynchronously and pass through synchronisers. The system clock samples them and must run at least 16 times faster than SCL, which covers fast-mode buses up to 400 kbit/s. The block never drives the bus high. It only asserts an open-drain pull-down request for SDA.

The block keeps an 8-bit register pointer from one transaction to the next:

- In a write transaction, the byte after the address is a sub-address that loads the pointer. Each byte after that is stored at the pointer, which then steps by one.
- A read transaction has no sub-address. It streams bytes from the pointer onward.
- To move the pointer before a read, the host sends a write that carries only the sub-address.

The register bank has two kinds of location:

- Control registers at the low addresses, readable and writable, driven out on a parallel bus.
- Read-only status bytes, taken from a parallel input.

Every other address reads as zero and ignores writes.

The protocol engine has ten states, with these transitions:

- IDLE: waits for a START.
- ADDR: shifts in the address byte. When the upper seven bits match the strapped address it moves to ADDR_ACK. Otherwise it moves to HOLD.
- ADDR_ACK: drives ACK. It then moves to SUB for a write or RDAT for a read.
- SUB: receives the sub-address, then moves to SUB_ACK.
- SUB_ACK: drives ACK and loads the pointer, then moves to WDAT.
- WDAT: receives a data byte, then moves to WDAT_ACK.
- WDAT_ACK: drives ACK and commits the byte, then moves back to WDAT.
- RDAT: shifts a byte out, then moves to RACK.
- RACK: samples the host's answer. On ACK it moves back to RDAT. On NACK it moves to HOLD.
- HOLD: releases the bus and waits.

From any state, a START moves the engine to ADDR, and a STOP or a low enable moves it to IDLE.

Top module: `i2c_reg_target`

## Requirements
- R1: While `en` is low the block ignores all bus activity: it releases SDA within one clock, gives no ACK, and changes no register.
- R2: The 7-bit bus address is 0x5E minus the strap value: strap 0 gives 0x5E, 1 gives 0x5D, 2 gives 0x5C and 3 gives 0x5B. The first byte after START carries this address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read).
- R3: The address byte is acknowledged only when its upper seven bits match. On a mismatch SDA stays released until the next START.
- R4: In a write, every byte after the address is acknowledged. Each data byte after the sub-address is committed to the register at the pointer in the cycle the ACK is driven.
- R5: A read sends bytes MSB first, starting at the pointer. A host ACK brings the next byte. A host NACK releases SDA until STOP or a repeated START.
- R6: The pointer is 0x00 after reset. It steps by one after each acknowledged data byte: a written byte acknowledged by the block, or a read byte acknowledged by the host. It keeps its value between transactions and wraps from 0xFF to 0x00.
- R7: A write that carries only a sub-address followed by STOP or a repeated START loads the pointer and changes no register.
- R8: Addresses 0x00 to 0x07 are read/write control registers. Addresses 0x20 and 0x21 return status bytes 0 and 1 of `stat_in` and ignore writes. Every other address reads 0x00 and ignores writes.
- R9: A START or STOP that arrives before a byte is complete aborts that byte without committing it.
- R10: The block changes its SDA pull-down only while the synchronised SCL is low.
- R11: After reset SDA is released and every control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable; the bus is ignored while low |
| strap | input | 2 | Address strap value (selects the bus address) |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain request) |
| stat_in | input | NSTAT*8 | Status bytes, byte 0 in bits 7:0, read at STAT_BASE onward |
| ctrl_q | output | NCTL*8 | Control register contents, register i in bits 8i+7:8i |

## Verification
The assertions assume the host follows the bus protocol:

- SDA changes only while SCL is low, except for START and STOP.
- The host issues no START or STOP while the block is holding SDA low.
- Each SCL phase lasts well beyond the three-clock synchroniser and edge-detect delay.

The stimulus keeps to these conditions. Its bus tasks move SDA only in the middle of the SCL low phase and make each phase ten system clocks long. Repeated STARTs and STOPs are placed only where the block has released SDA: after a NACKed read byte, or partway through a byte the host is sending. On the bench, SDA is a wired-AND of the host drive and the block's pull-down.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int ADR_W  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_HOLD
    } tgt_state_e;

    function automatic logic [ADR_W-1:0] strap_to_addr(input logic [1:0] s);
        logic [ADR_W-1:0] a;
        case (s)
            2'd0:    a = 7'h5E;
            2'd1:    a = 7'h5D;
            2'd2:    a = 7'h5C;
            default: a = 7'h5B;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_a,
    input  logic sda_a,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_m;
    logic [STAGES-1:0] sda_m;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= '1;
            sda_m <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= {scl_m[STAGES-2:0], scl_a};
            sda_m <= {sda_m[STAGES-2:0], sda_a};
            scl_d <= scl_m[STAGES-1];
            sda_d <= sda_m[STAGES-1];
        end
    end

    assign scl_q     = scl_m[STAGES-1];
    assign sda_q     = sda_m[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADR_W-1:0]  my_addr,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              ptr_load
);

    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    tgt_state_e        state_q;
    tgt_state_e        state_n;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] sh;
    logic              host_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        if (!en) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR:
                    if (scl_fall && cnt == FULL)
                        state_n = (sh[BYTE_W-1:1] == my_addr) ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK:
                    if (scl_fall) state_n = sh[0] ? ST_RDAT : ST_SUB;
                ST_SUB:
                    if (scl_fall && cnt == FULL) state_n = ST_SUB_ACK;
                ST_SUB_ACK:
                    if (scl_fall) state_n = ST_WDAT;
                ST_WDAT:
                    if (scl_fall && cnt == FULL) state_n = ST_WDAT_ACK;
                ST_WDAT_ACK:
                    if (scl_fall) state_n = ST_WDAT;
                ST_RDAT:
                    if (scl_fall && cnt == LAST) state_n = ST_RACK;
                ST_RACK:
                    if (scl_fall) state_n = host_ack ? ST_RDAT : ST_HOLD;
                ST_HOLD: ;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_SUB_ACK, ST_WDAT_ACK: sda_pull = 1'b1;
            ST_RDAT:                              sda_pull = ~sh[BYTE_W-1];
            default:                              sda_pull = 1'b0;
        endcase
    end

    // byte datapath, pointer and commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            cnt      <= '0;
            ptr      <= '0;
            host_ack <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            ptr_load <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            ptr_load <= 1'b0;
            if (!en || start_det || stop_det) begin
                cnt <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_SUB, ST_WDAT: begin
                        if (scl_rise && cnt != FULL) begin
                            sh  <= {sh[BYTE_W-2:0], sda_q};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state_q == ST_SUB) begin
                                ptr      <= PTR_W'(sh);
                                ptr_load <= 1'b1;
                            end else if (state_q == ST_WDAT) begin
                                wr_stb  <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= sh;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall && sh[0]) sh <= rd_data;
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (cnt == LAST) begin
                                cnt <= '0;
                            end else begin
                                sh  <= sh << 1;
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_q;
                            if (!sda_q) ptr <= ptr + 1'b1;
                        end
                        if (scl_fall && host_ack) sh <= rd_data;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
    import i2ct_pkg::*;
#(
    parameter int NCTL      = 8,
    parameter int NSTAT     = 2,
    parameter int STAT_BASE = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [PTR_W-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [PTR_W-1:0]        rd_addr,
    input  logic [NSTAT*BYTE_W-1:0] stat_in,
    output logic [NCTL*BYTE_W-1:0]  ctrl_q,
    output logic [BYTE_W-1:0]       rd_data
);

    logic [BYTE_W-1:0] ctrl_r [NCTL];

    for (genvar g = 0; g < NCTL; g++) begin : g_ctl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_r[g] <= '0;
            else if (wr_stb && wr_addr == PTR_W'(g))
                ctrl_r[g] <= wr_data;
        end
        assign ctrl_q[g*BYTE_W +: BYTE_W] = ctrl_r[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCTL; i++)
            if (rd_addr == PTR_W'(i)) rd_data = ctrl_r[i];
        for (int j = 0; j < NSTAT; j++)
            if (rd_addr == PTR_W'(STAT_BASE + j)) rd_data = stat_in[j*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2ct_pkg::*;
#(
    parameter int NCTL      = 8,
    parameter int NSTAT     = 2,
    parameter int STAT_BASE = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [1:0]              strap,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_o,
    input  logic [NSTAT*BYTE_W-1:0] stat_in,
    output logic [NCTL*BYTE_W-1:0]  ctrl_q
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_stb;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [PTR_W-1:0]  reg_ptr;
    logic              ptr_load;
    logic [BYTE_W-1:0] rd_data;
    logic [ADR_W-1:0]  my_addr;

    assign my_addr = strap_to_addr(strap);

    i2ct_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_a     (scl_i),
        .sda_a     (sda_i),
        .scl_q     (scl_s),
        .sda_q     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2ct_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .my_addr   (my_addr),
        .sda_q     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull_o),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (reg_ptr),
        .ptr_load  (ptr_load)
    );

    i2ct_regs #(
        .NCTL      (NCTL),
        .NSTAT     (NSTAT),
        .STAT_BASE (STAT_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (reg_ptr),
        .stat_in (stat_in),
        .ctrl_q  (ctrl_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
    import i2ct_pkg::*;
#(
    parameter int NCTL = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en,
    input logic                   scl_q,
    input logic                   sda_pull,
    input logic                   wr_stb,
    input logic [PTR_W-1:0]       wr_addr,
    input logic [BYTE_W-1:0]      wr_data,
    input logic [PTR_W-1:0]       ptr,
    input logic                   ptr_load,
    input logic [NCTL*BYTE_W-1:0] ctrl_q
);

    logic              last_hit;
    logic [PTR_W-1:0]  last_addr;
    logic [BYTE_W-1:0] last_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_hit  <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            last_hit  <= wr_stb && (int'(wr_addr) < NCTL);
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    // R1
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sda_pull);

    // R10
    a_r10_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && scl_q && $past(scl_q)) |-> $stable(sda_pull));

    // R4
    a_r4_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        last_hit |-> ctrl_q[int'(last_addr)*BYTE_W +: BYTE_W] == last_data);

    // R8
    a_r8_outside_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && int'(wr_addr) >= NCTL) |=> $stable(ctrl_q));

    // R6
    a_r6_ptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_load |-> (ptr == $past(ptr) || ptr == $past(ptr) + 8'd1));

endmodule

bind i2c_reg_target i2ct_checker #(.NCTL(NCTL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .scl_q    (scl_s),
    .sda_pull (sda_pull_o),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ptr      (reg_ptr),
    .ptr_load (ptr_load),
    .ctrl_q   (ctrl_q)
);

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;

    localparam int NCTL  = 8;
    localparam int NSTAT = 2;
    localparam int SBASE = 32;
    localparam int Q     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [1:0] strap = 2'd0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [NSTAT*8-1:0] stat_in = 16'hC35A;
    logic [NCTL*8-1:0]  ctrl_q;

    int n_vec = 0;
    int n_bad = 0;
    int off_pull = 0;
    int hi_change = 0;
    logic scl_prev = 1'b1;
    logic pull_prev = 1'b0;
    logic [7:0] model [NCTL];

    localparam logic [7:0] DEV_W = 8'hBC;
    localparam logic [7:0] DEV_R = 8'hBD;

    assign sda_line = sda_drv & ~sda_pull;

    always #5 clk = ~clk;

    i2c_reg_target #(.NCTL(NCTL), .NSTAT(NSTAT), .STAT_BASE(SBASE)) u_i2c_reg_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .strap      (strap),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .stat_in    (stat_in),
        .ctrl_q     (ctrl_q)
    );

    always @(negedge clk) begin
        if (rst_n && !en && sda_pull) off_pull++;
        if (rst_n && en && scl && scl_prev && sda_pull !== pull_prev) hi_change++;
        scl_prev  <= scl;
        pull_prev <= sda_pull;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q);
        scl = 1'b1;     tick(2*Q);
        sda_drv = 1'b0; tick(2*Q);
        scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl = 1'b1;     tick(2*Q);
        sda_drv = 1'b1; tick(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_drv = b; tick(Q);
        scl = 1'b1;  tick(Q);
        s = sda_line; tick(Q);
        scl = 1'b0;  tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 0; i < n; i++) clk_bit(b[7-i], s);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic k;
        bus_start();
        send_byte(DEV_W, k);
        send_byte(a, k);
        bus_stop();
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NCTL; i++)
            check(tag, 32'(ctrl_q[i*8 +: 8]), 32'(model[i]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic       k;
        logic [7:0] d;
        for (int i = 0; i < NCTL; i++) model[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R11 reset state
        check("R11 sda released", 32'(sda_pull), 0);
        check_bank("R11 ctrl zero");

        en = 1'b1;
        tick(4);

        // R2 R3 strap sweep against every table address
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            tick(2);
            for (int c = 0; c < 4; c++) begin
                logic [6:0] a;
                a = 7'(8'h5E - 8'(c));
                bus_start();
                send_byte({a, 1'b0}, k);
                bus_stop();
                check("R2 R3 address match", 32'(k), 32'(s == c));
            end
        end
        strap = 2'd0;
        bus_start();
        send_byte(8'hA0, k);
        check("R3 foreign address nack", 32'(k), 0);
        check("R3 released after mismatch", 32'(sda_pull), 0);
        bus_stop();

        // R1 disabled
        en = 1'b0;
        bus_start();
        send_byte(DEV_W, k);
        check("R1 no ack while off", 32'(k), 0);
        send_byte(8'h00, k);
        send_byte(8'h77, k);
        bus_stop();
        en = 1'b1;
        tick(4);
        check_bank("R1 no write while off");
        check("R1 no pull while off", 32'(off_pull), 0);

        // R4 burst write 0..7
        bus_start();
        send_byte(DEV_W, k);
        check("R4 address ack", 32'(k), 1);
        send_byte(8'h00, k);
        check("R4 sub ack", 32'(k), 1);
        for (int i = 0; i < NCTL; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 5) & 8'hFF);
            send_byte(v, k);
            model[i] = v;
            check("R4 data ack", 32'(k), 1);
            check("R4 committed", 32'(ctrl_q[i*8 +: 8]), 32'(v));
        end
        bus_stop();

        // R7 pointer only
        set_ptr(8'h02);
        check_bank("R7 no register change");

        // R5 R6 read with ack/nack
        bus_start();
        send_byte(DEV_R, k);
        check("R5 read address ack", 32'(k), 1);
        recv_byte(1'b1, d); check("R5 R7 byte at sub", 32'(d), 32'(model[2]));
        recv_byte(1'b1, d); check("R5 R6 next byte", 32'(d), 32'(model[3]));
        recv_byte(1'b0, d); check("R5 R6 third byte", 32'(d), 32'(model[4]));
        tick(4);
        check("R5 released after nack", 32'(sda_pull), 0);
        bus_stop();
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d); check("R6 nack byte not counted", 32'(d), 32'(model[4]));
        bus_stop();
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b1, d); check("R6 persists", 32'(d), 32'(model[4]));
        recv_byte(1'b0, d); check("R6 steps", 32'(d), 32'(model[5]));
        bus_stop();

        // R5 full sweep
        set_ptr(8'h00);
        bus_start();
        send_byte(DEV_R, k);
        for (int i = 0; i < NCTL; i++) begin
            recv_byte(i != NCTL - 1, d);
            check("R5 sweep", 32'(d), 32'(model[i]));
        end
        bus_stop();

        // R8 unimplemented and status
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h10, k);
        send_byte(8'hAA, k);
        check("R8 outside write acked", 32'(k), 1);
        bus_stop();
        check_bank("R8 outside write ignored");
        for (int j = 0; j < 5; j++) begin
            logic [7:0] a;
            a = (j == 0) ? 8'h08 : (j == 1) ? 8'h10 : (j == 2) ? 8'h22 : (j == 3) ? 8'h80 : 8'hFE;
            set_ptr(a);
            bus_start();
            send_byte(DEV_R, k);
            recv_byte(1'b0, d);
            bus_stop();
            check("R8 unimplemented reads zero", 32'(d), 0);
        end
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'(SBASE), k);
        send_byte(8'h11, k);
        bus_stop();
        set_ptr(8'(SBASE));
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b1, d); check("R8 status byte 0", 32'(d), 32'(stat_in[7:0]));
        recv_byte(1'b0, d); check("R8 status byte 1", 32'(d), 32'(stat_in[15:8]));
        bus_stop();

        // R6 wrap
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'hFF, k);
        send_byte(8'h66, k);
        send_byte(8'h99, k);
        bus_stop();
        model[0] = 8'h99;
        check_bank("R6 wrap to zero");
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d);
        bus_stop();
        check("R6 pointer after wrap", 32'(d), 32'(model[1]));

        // R9 abort by START, then R7 repeated-start read
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h03, k);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d);
        bus_stop();
        check("R9 start abort read", 32'(d), 32'(model[3]));
        check_bank("R9 start abort no commit");
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h04, k);
        send_bits(8'h0F, 5);
        bus_stop();
        check_bank("R9 stop abort no commit");
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h06, k);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d);
        bus_stop();
        check("R7 repeated start read", 32'(d), 32'(model[6]));

        check("R10 sda steady while scl high", 32'(hi_change), 0);
        check("R1 never pulled while off", 32'(off_pull), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule